// File: doc/BRIEF.md
# Memory Request Coalescing Unit

This unit receives one batch of up to sixteen per-lane byte addresses and turns it into a short series of aligned memory transactions. Each lane has an active bit. Lanes whose bit is clear are left out of the batch completely. Each round starts at the lowest-numbered lane that has not yet been serviced. The unit takes the aligned segment that holds that lane's address and collects every other pending lane whose address falls in the same segment. It then halves the transaction for as long as all the collected addresses stay inside one half, down to a floor of 32 bytes.

A strict mode is also available for requesters that can only use in-order access. In this mode a batch is merged only when every active lane k reads element k of a single aligned segment. When the batch does not match that pattern, each active lane gets its own 32-byte transaction, in ascending lane order. Batches come in through a valid/ready handshake and transactions leave through a second one. A one-cycle done pulse closes every batch, including a batch with no active lanes.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, and again after any reset in the middle of a batch, in_ready is 1 and out_valid and done are 0.
- R2: A transaction mask never includes an inactive lane or a lane already serviced in the same batch. The masks of one batch together cover every active lane exactly once.
- R3: Every transaction includes the lowest-numbered lane still pending. Transactions are issued in ascending order of that lane, and a batch produces exactly the number of transactions the rules below give.
- R4: The segment size comes from in_elem: code 0 (1-byte elements) uses 32 bytes, code 1 (2-byte) uses 64 bytes, and codes 2 and 3 (4-byte and 8-byte) use 128 bytes.
- R5: In relaxed mode (in_strict = 0), every pending lane whose address lies in the leader's segment joins the leader's transaction.
- R6: A 128-byte transaction whose addresses all lie in one 64-byte half shrinks to 64 bytes. A 64-byte transaction whose addresses all lie in one 32-byte half shrinks to 32 bytes. out_size reports 0 for 32 bytes, 1 for 64 and 2 for 128, and never reports 3.
- R7: out_base is the leader's address aligned down to the final transaction size.
- R8: In strict mode (in_strict = 1), when a base B aligned to the segment size exists such that every active lane k has address B + k × element bytes, the whole batch leaves as a single transaction, shrunk as R6 describes.
- R9: In strict mode when that pattern fails, each active lane gets its own 32-byte transaction, in ascending lane order.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_base, out_size and out_mask hold their values.
- R11: done is 1 for exactly one cycle. It rises in the cycle after the handshake of the batch's last transaction. A batch with no active lanes produces done alone, with no transaction.
- R12: in_ready is 1 only while no batch is in progress, and it is never 1 in the same cycle as out_valid or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A batch is offered |
| in_ready | output | 1 | The unit can accept a batch |
| in_mask | input | LANES | Active bit for each lane |
| in_addr | input | LANES*AW | Byte address of each lane; lane k occupies bits [k*AW +: AW] |
| in_elem | input | 2 | Element size code (see R4) |
| in_strict | input | 1 | 1 selects strict in-order merging |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | The downstream side takes the transaction |
| out_base | output | AW | Aligned base address of the transaction |
| out_size | output | 2 | Transaction size code: 0 = 32, 1 = 64, 2 = 128 bytes |
| out_mask | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse that ends a batch |

## Verification
The bench uses the default LANES = 16 and AW = 32. Sixteen lanes are enough for a 4-byte or 8-byte stride to cross a 128-byte boundary, so one batch can split into two segments. They are also enough for a reversed lane order to break the strict pattern. Thirty-two address bits let the bases sit well above zero, which tests whether alignment and halving decisions depend on the segment position and not only on the offset. Sparse masks, misaligned strict bases, stalls and an all-inactive batch cover the remaining corners.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    TX32  = 2'd0,
    TX64  = 2'd1,
    TX128 = 2'd2
  } txn_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } coal_state_e;

  // segment granule chosen by the element size code
  function automatic txn_size_e seg_for_elem(input logic [1:0] elem);
    case (elem)
      2'd0:    return TX32;
      2'd1:    return TX64;
      default: return TX128;
    endcase
  endfunction

  function automatic logic [7:0] size_to_bytes(input txn_size_e s);
    return 8'd32 << s;
  endfunction

  // halve while the grouped addresses stay inside one half
  function automatic txn_size_e shrink_size(input txn_size_e seg,
                                            input logic same_b6,
                                            input logic same_b5);
    txn_size_e s;
    s = seg;
    if (s == TX128 && same_b6) s = TX64;
    if (s == TX64 && same_b5) s = TX32;
    return s;
  endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0]         req,
  output logic                     any,
  output logic [$clog2(LANES)-1:0] idx
);
  localparam int LW = $clog2(LANES);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) idx = LW'(i);
    end
  end
endmodule

// File: rtl/coal_order_check.sv
module coal_order_check
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    mask,
  input  logic [1:0]          elem,
  output logic                ordered
);
  localparam int LW = $clog2(LANES);

  logic          first_any;
  logic [LW-1:0] first_idx;
  logic [AW-1:0] first_addr, ref_base;
  logic [LANES-1:0] lane_ok;
  logic [7:0]    seg_bytes;
  logic          ref_aligned;

  coal_leader #(.LANES(LANES)) u_first (
    .req(mask), .any(first_any), .idx(first_idx)
  );

  assign first_addr  = addr[first_idx*AW +: AW];
  assign ref_base    = first_addr - (AW'(first_idx) << elem);
  assign seg_bytes   = size_to_bytes(seg_for_elem(elem));
  assign ref_aligned = (ref_base[7:0] & (seg_bytes - 8'd1)) == 8'd0;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr   = addr[gi*AW +: AW];
    assign lane_ok[gi] = !mask[gi] ||
                         ((lane_addr - (AW'(gi) << elem)) == ref_base);
  end

  assign ordered = first_any ? (&lane_ok && ref_aligned) : 1'b1;
endmodule

// File: rtl/coal_group.sv
module coal_group
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0]      addr,
  input  logic [LANES-1:0]         pend,
  input  logic [$clog2(LANES)-1:0] lead,
  input  logic [1:0]               elem,
  input  logic                     strict,
  input  logic                     ordered,
  output logic [LANES-1:0]         members,
  output txn_size_e                size,
  output logic [AW-1:0]            base
);
  logic [AW-1:0]    lead_addr;
  txn_size_e        seg;
  logic [LANES-1:0] in_seg, eq_b6, eq_b5;
  logic             same_b6, same_b5;

  assign lead_addr = addr[lead*AW +: AW];
  assign seg       = seg_for_elem(elem);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [AW-1:0] a;
    logic          hit;
    assign a = addr[gi*AW +: AW];
    always_comb begin
      case (seg)
        TX32:    hit = a[AW-1:5] == lead_addr[AW-1:5];
        TX64:    hit = a[AW-1:6] == lead_addr[AW-1:6];
        default: hit = a[AW-1:7] == lead_addr[AW-1:7];
      endcase
    end
    assign in_seg[gi] = pend[gi] && hit;
    assign eq_b6[gi]  = a[6] == lead_addr[6];
    assign eq_b5[gi]  = a[5] == lead_addr[5];
  end

  always_comb begin
    if (strict && !ordered) begin
      members = LANES'(1) << lead;
    end else if (strict) begin
      members = pend;
    end else begin
      members = in_seg;
    end
    same_b6 = &(~members | eq_b6);
    same_b5 = &(~members | eq_b5);
    if (strict && !ordered) size = TX32;
    else                    size = shrink_size(seg, same_b6, same_b5);
    base = lead_addr & ~(AW'(size_to_bytes(size)) - AW'(1));
  end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    in_mask,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [1:0]          in_elem,
  input  logic                in_strict,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_base,
  output logic [1:0]          out_size,
  output logic [LANES-1:0]    out_mask,
  output logic                done
);
  localparam int LW = $clog2(LANES);

  coal_state_e         state;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES-1:0]    act_q, pend_q;
  logic [1:0]          elem_q;
  logic                strict_q;

  logic             ordered;
  logic             lead_any;
  logic [LW-1:0]    lead_idx;
  logic [LANES-1:0] grp_members;
  txn_size_e        grp_size;
  logic [AW-1:0]    grp_base;

  // named events
  logic             batch_take, txn_fire;
  logic [LANES-1:0] pend_next;

  coal_order_check #(.LANES(LANES), .AW(AW)) u_order (
    .addr(addr_q), .mask(act_q), .elem(elem_q), .ordered(ordered)
  );

  coal_leader #(.LANES(LANES)) u_leader (
    .req(pend_q), .any(lead_any), .idx(lead_idx)
  );

  coal_group #(.LANES(LANES), .AW(AW)) u_group (
    .addr(addr_q), .pend(pend_q), .lead(lead_idx), .elem(elem_q),
    .strict(strict_q), .ordered(ordered),
    .members(grp_members), .size(grp_size), .base(grp_base)
  );

  assign in_ready   = state == ST_IDLE;
  assign out_valid  = (state == ST_ISSUE) && lead_any;
  assign done       = state == ST_FIN;
  assign out_base   = grp_base;
  assign out_size   = grp_size;
  assign out_mask   = grp_members;

  assign batch_take = in_valid && in_ready;
  assign txn_fire   = out_valid && out_ready;
  assign pend_next  = pend_q & ~grp_members;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      act_q    <= '0;
      pend_q   <= '0;
      elem_q   <= '0;
      strict_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (batch_take) begin
          addr_q   <= in_addr;
          act_q    <= in_mask;
          pend_q   <= in_mask;
          elem_q   <= in_elem;
          strict_q <= in_strict;
          state    <= (in_mask == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: if (txn_fire) begin
          pend_q <= pend_next;
          if (pend_next == '0) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_base,
  input logic [1:0]       out_size,
  input logic [LANES-1:0] out_mask,
  input logic             done,
  input logic [LANES-1:0] act_mask,
  input logic [LANES-1:0] pend_mask,
  input logic             strict_mode,
  input logic             ordered
);
  logic [LANES-1:0] lowest_pend;
  assign lowest_pend = pend_mask & (~pend_mask + LANES'(1));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_base) &&
                                   $stable(out_size) && $stable(out_mask)));

  assert_active_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~act_mask) == '0));

  assert_no_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~pend_mask) == '0));

  assert_leader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & lowest_pend) != '0));

  assert_size_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size != 2'd3));

  assert_base_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_base & ((AW'(32) << out_size) - AW'(1))) == '0));

  assert_single_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && strict_mode && !ordered) |->
      ($countones(out_mask) == 1 && out_size == 2'd0));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !done));
endmodule

bind mem_coalescer coal_checker #(.LANES(LANES), .AW(AW)) u_coal_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_base(out_base), .out_size(out_size),
  .out_mask(out_mask), .done(done), .act_mask(act_q), .pend_mask(pend_q),
  .strict_mode(strict_q), .ordered(ordered)
);

// File: tb/mem_coalescer_test.sv
`timescale 1ns/1ps
module mem_coalescer_test;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES-1:0]    in_mask = '0;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [1:0]          in_elem = '0;
  logic                in_strict = 1'b0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [AW-1:0]       out_base;
  logic [1:0]          out_size;
  logic [LANES-1:0]    out_mask;
  logic                done;

  always #2 clk = ~clk;  // 250 MHz

  mem_coalescer #(.LANES(LANES), .AW(AW)) uut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus: mask, elem code, strict, reversed, base, stride, expected transaction count
  typedef struct packed {
    logic [15:0] mask;
    logic [1:0]  elem;
    logic        strict;
    logic        rev;
    logic [31:0] base;
    logic [31:0] stride;
    logic [7:0]  n;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 2'd2, 1'b0, 1'b0, 32'h1000, 32'd4,  8'd1},  // R5 R6 shrink to 64
    '{16'hFFFF, 2'd3, 1'b0, 1'b0, 32'h2000, 32'd8,  8'd1},  // R4 8-byte -> 128
    '{16'hFFFF, 2'd0, 1'b0, 1'b0, 32'h3000, 32'd1,  8'd1},  // R4 1-byte -> 32
    '{16'hFFFF, 2'd1, 1'b0, 1'b0, 32'h4000, 32'd2,  8'd1},  // R6 64 -> 32
    '{16'hFFFF, 2'd2, 1'b0, 1'b0, 32'h1000, 32'd16, 8'd2},  // R3 two segments
    '{16'hFFFF, 2'd2, 1'b0, 1'b1, 32'h1000, 32'd4,  8'd1},  // R5 reversed still merges
    '{16'hFFFF, 2'd2, 1'b1, 1'b1, 32'h1000, 32'd4,  8'd16}, // R9 reversed strict
    '{16'hFFFF, 2'd2, 1'b1, 1'b0, 32'h1000, 32'd4,  8'd1},  // R8 ordered
    '{16'h00F0, 2'd2, 1'b0, 1'b0, 32'h1000, 32'd4,  8'd1},  // R2 sparse
    '{16'h0000, 2'd2, 1'b0, 1'b0, 32'h1000, 32'd4,  8'd0},  // R11 empty batch
    '{16'hA5A5, 2'd2, 1'b1, 1'b0, 32'h1000, 32'd4,  8'd1},  // R8 sparse ordered
    '{16'hFFFF, 2'd2, 1'b1, 1'b0, 32'h1004, 32'd4,  8'd16}, // R9 misaligned base
    '{16'hFFFF, 2'd1, 1'b0, 1'b0, 32'h1030, 32'd2,  8'd2},  // R6 R7 upper-half 32s
    '{16'hFFFF, 2'd0, 1'b1, 1'b0, 32'h3000, 32'd1,  8'd1},  // R8 1-byte strict
    '{16'hFFFF, 2'd3, 1'b0, 1'b0, 32'h2040, 32'd8,  8'd2}   // R6 two 64-byte halves
  };

  int unsigned a  [LANES];
  int unsigned eb [LANES];
  int unsigned es [LANES];
  logic [15:0] em [LANES];
  int          en;

  function automatic int unsigned halve(input int unsigned seg, input int unsigned lo,
                                        input int unsigned hi);
    int unsigned s;
    s = seg;
    while (s > 32 && (lo / (s / 2)) == (hi / (s / 2))) s = s / 2;
    return s;
  endfunction

  task automatic build_model(input logic [15:0] mask, input logic [1:0] elem, input logic strict);
    int unsigned esz, seg, r, lo, hi, sz;
    int first;
    bit ok;
    logic [15:0] pend, m;
    esz = 1 << elem;
    seg = (elem == 0) ? 32 : (elem == 1) ? 64 : 128;
    en  = 0;
    if (mask == 0) return;
    if (strict) begin
      first = -1;
      for (int k = LANES - 1; k >= 0; k--) if (mask[k]) first = k;
      r  = a[first] - first * esz;
      ok = (r % seg) == 0;
      lo = 32'hFFFF_FFFF; hi = 0;
      for (int k = 0; k < LANES; k++) if (mask[k]) begin
        if (a[k] != r + k * esz) ok = 0;
        if (a[k] < lo) lo = a[k];
        if (a[k] > hi) hi = a[k];
      end
      if (ok) begin
        sz = halve(seg, lo, hi);
        eb[0] = a[first] - a[first] % sz; es[0] = sz; em[0] = mask; en = 1;
      end else begin
        for (int k = 0; k < LANES; k++) if (mask[k]) begin
          eb[en] = a[k] - a[k] % 32; es[en] = 32; em[en] = 16'(1) << k; en++;
        end
      end
    end else begin
      pend = mask;
      while (pend != 0) begin
        first = -1;
        for (int k = LANES - 1; k >= 0; k--) if (pend[k]) first = k;
        m = 0; lo = 32'hFFFF_FFFF; hi = 0;
        for (int k = 0; k < LANES; k++)
          if (pend[k] && (a[k] / seg) == (a[first] / seg)) begin
            m[k] = 1'b1;
            if (a[k] < lo) lo = a[k];
            if (a[k] > hi) hi = a[k];
          end
        sz = halve(seg, lo, hi);
        eb[en] = a[first] - a[first] % sz; es[en] = sz; em[en] = m; en++;
        pend = pend & ~m;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input bit bp, input bit stall);
    int got, cyc;
    bit seen_done;
    logic [15:0] cover_m, overlap;
    logic [AW-1:0] hb; logic [1:0] hs; logic [15:0] hm;
    for (int k = 0; k < LANES; k++) begin
      a[k] = v.rev ? v.base + (LANES - 1 - k) * v.stride : v.base + k * v.stride;
      in_addr[k*AW +: AW] = a[k];
    end
    build_model(v.mask, v.elem, v.strict);
    @(negedge clk);
    in_mask = v.mask; in_elem = v.elem; in_strict = v.strict; in_valid = 1'b1;
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R12 idle ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R12 busy not ready", in_ready, 0);
    if (stall) begin
      hb = out_base; hs = out_size; hm = out_mask;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b1 && out_base == hb && out_size == hs && out_mask == hm,
          "R10 stall hold", {out_valid, out_mask}, {1'b1, hm});
    end
    got = 0; cyc = 0; seen_done = 0; cover_m = 0; overlap = 0;
    while (!seen_done && cyc < 300) begin
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (out_valid && out_ready) begin
        if (got < en) begin
          chk(out_base == eb[got], "R7 base", out_base, eb[got]);
          chk((32 << out_size) == es[got], "R4/R6 size", 32 << out_size, es[got]);
          chk(out_mask == em[got], v.strict ? "R8/R9 mask" : "R5 mask", out_mask, em[got]);
        end
        overlap = overlap | (cover_m & out_mask);
        cover_m = cover_m | out_mask;
        got++;
      end
      if (done) seen_done = 1;
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(got == int'(v.n), "R3 transaction count", got, v.n);
    chk(cover_m == v.mask && overlap == 0, "R2 lane coverage", cover_m, v.mask);
    chk(seen_done, "R11 done seen", seen_done, 1);
    chk(done == 1'b0 && in_ready == 1'b1, "R11 single done pulse", {done, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 reset state",
        {in_ready, out_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 after release",
        {in_ready, out_valid, done}, 3'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 2 == 1, 1'b0);

    // R10 stall on a two-segment batch
    run_vec(VECS[4], 1'b0, 1'b1);
    // R9 strict single-lane sequence under backpressure
    run_vec(VECS[6], 1'b1, 1'b1);

    // R1 reset in the middle of a batch
    @(negedge clk);
    in_mask = 16'hFFFF; in_elem = 2'd2; in_strict = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1 batch in flight", out_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 mid-batch reset",
        {in_ready, out_valid, done}, 3'b100);
    rst_n = 1'b1;
    run_vec(VECS[0], 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule